// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block sits on the host side of an enhanced bidirectional parallel link. It turns one local register request into exactly one interlocked bus cycle toward a peripheral. The cycle can be a data write, a data read, an address write or an address read. The block drives the write-direction line and two active-low strobes, one for data and one for address. It drives the 8-bit bus as separate output, output-enable and input vectors, and it watches the peripheral's active-low wait line. The wait line passes through a synchronizer before the cycle logic uses it.

On the local side a request carries a register offset, a read/write flag and write data. Offset 4 selects a data cycle, offset 3 selects an address cycle, and every other offset completes at once without touching the bus. Completion is a one-clock `done_o` pulse. Read data and a timeout flag are valid from that pulse onward.

In compliant mode the strobe waits until the peripheral shows wait low. A strap input selects a legacy variant in which the strobe goes out at cycle start whatever the level of wait. Each wait for the peripheral is bounded by a programmable clock count; a limit of 0 turns the bound off.

Top module: `epp_host_ctrl`

## Requirements
- R1: A request at offset 4 pulses only `ndstb_o` low, and a request at offset 3 pulses only `nastb_o` low; the two strobes are never low together.
- R2: In a write cycle, `nwrite_o` is low and `bus_oe_o` is high with `bus_o` equal to the write data at least one clock before the strobe falls, and `bus_o` stays unchanged while the strobe is low.
- R3: In compliant mode (`legacy_i`=0) a strobe falls only after the synchronized wait line has been seen low. While `nwait_i` is held high (with limit 0), no strobe is asserted and no completion is reported.
- R4: A strobe rises only after the synchronized wait line has been seen high, or on a timeout.
- R5: A request that ran a bus cycle completes only after the wait line has been seen low again after the strobe rose, unless it timed out.
- R6: In legacy mode (`legacy_i`=1) the strobe is asserted even while `nwait_i` is high, and the cycle then completes normally.
- R7: In a read cycle, `nwrite_o` stays high and `bus_oe_o` stays low, and `rdata_o` returns the `bus_i` value present when wait was seen high.
- R8: With `tmo_lim_i` nonzero, a wait longer than the limit ends the cycle: both strobes go high, `done_o` pulses and `tmo_o` reads 1. If the timeout hits before the strobe, no strobe is issued.
- R9: After reset and whenever no cycle is active, `nwrite_o`=1, `ndstb_o`=1, `nastb_o`=1 and `bus_oe_o`=0, including in the clock where `done_o` is high.
- R10: A request at any offset other than 3 or 4 completes without any strobe, with `tmo_o`=0.
- R11: `done_o` is high for exactly one clock per request, and `tmo_o` is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_i | input | 1 | 1: strobe not held off by wait |
| tmo_lim_i | input | TMO_W | Wait limit in clocks, 0 disables |
| req_i | input | 1 | Request pulse, taken when idle |
| req_off_i | input | OFF_W | Register offset (3 address, 4 data) |
| req_we_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | DW | Last read data |
| tmo_o | output | 1 | Last request timed out |
| nwrite_o | output | 1 | Write direction, active low |
| ndstb_o | output | 1 | Data strobe, active low |
| nastb_o | output | 1 | Address strobe, active low |
| bus_o | output | DW | Bus output data |
| bus_oe_o | output | 1 | Bus output enable |
| bus_i | input | DW | Bus input data |
| nwait_i | input | 1 | Peripheral wait, active low |

## Verification
The assertions assume that requests arrive only while the block is idle. They also assume that `legacy_i` does not change during a cycle and that the peripheral holds `bus_i` steady from raising wait until the strobe rises. The bench drives requests only after the previous `done_o`. It changes mode and limit only between requests, and its peripheral model sets read data and raises wait on the same falling clock edge, keeping both until the strobe has returned high.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_GO, ST_STRB, ST_REL, ST_DONE
  } st_e;
  localparam int unsigned OFF_ADDR = 3;
  localparam int unsigned OFF_DATA = 4;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
      end
    end
  endgenerate
  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  // limit 0 disables the bound
  assign expired_o = (lim_i != '0) && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (run_i && !expired_o)   cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
  import epp_host_pkg::*;
#(
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8,
  parameter int OFF_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             legacy_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             req_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic             req_we_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic             tmo_o,
  output logic             nwrite_o,
  output logic             ndstb_o,
  output logic             nastb_o,
  output logic [DW-1:0]    bus_o,
  output logic             bus_oe_o,
  input  logic [DW-1:0]    bus_i,
  input  logic             nwait_i
);
  localparam logic [OFF_W-1:0] OffAddr = OFF_W'(OFF_ADDR);
  localparam logic [OFF_W-1:0] OffData = OFF_W'(OFF_DATA);

  st_e           st_q, st_d;
  logic          is_addr_q, we_q, op_valid_q, tmo_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          nwait_s, expired, cyc_act, strb;
  logic          set_tmo, cap_rd;

  epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nwait_i), .q_o(nwait_s)
  );

  epp_wait_timer #(.W(TMO_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(st_d != st_q),
    .run_i(st_q == ST_GO || st_q == ST_STRB || st_q == ST_REL),
    .lim_i(tmo_lim_i), .expired_o(expired)
  );

  always_comb begin
    st_d    = st_q;
    set_tmo = 1'b0;
    cap_rd  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = (req_off_i == OffAddr || req_off_i == OffData)
                                 ? ST_SETUP : ST_DONE;
      ST_SETUP: st_d = legacy_i ? ST_STRB : ST_GO;
      ST_GO: begin
        if (!nwait_s)     st_d = ST_STRB;
        else if (expired) begin st_d = ST_DONE; set_tmo = 1'b1; end
      end
      ST_STRB: begin
        if (nwait_s)      begin st_d = ST_REL; cap_rd = !we_q; end
        else if (expired) begin st_d = ST_DONE; set_tmo = 1'b1; end
      end
      ST_REL: begin
        if (!nwait_s)     st_d = ST_DONE;
        else if (expired) begin st_d = ST_DONE; set_tmo = 1'b1; end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      is_addr_q  <= 1'b0;
      we_q       <= 1'b0;
      op_valid_q <= 1'b0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      tmo_q      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) begin
        is_addr_q  <= (req_off_i == OffAddr);
        op_valid_q <= (req_off_i == OffAddr || req_off_i == OffData);
        we_q       <= req_we_i;
        wdata_q    <= req_wdata_i;
        tmo_q      <= 1'b0;
      end
      if (set_tmo) tmo_q   <= 1'b1;
      if (cap_rd)  rdata_q <= bus_i;
    end
  end

  assign cyc_act  = (st_q == ST_SETUP) || (st_q == ST_GO) ||
                    (st_q == ST_STRB)  || (st_q == ST_REL);
  assign strb     = (st_q == ST_STRB);
  assign ndstb_o  = !(strb && !is_addr_q);
  assign nastb_o  = !(strb && is_addr_q);
  assign nwrite_o = !(cyc_act && we_q);
  assign bus_oe_o = cyc_act && we_q;
  assign bus_o    = wdata_q;
  assign done_o   = (st_q == ST_DONE);
  assign rdata_o  = rdata_q;
  assign tmo_o    = tmo_q;
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          legacy_i,
  input logic          done_o,
  input logic          tmo_o,
  input logic          nwrite_o,
  input logic          ndstb_o,
  input logic          nastb_o,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          nwait_s,
  input logic          op_valid_q
);
  logic strb_lo;
  assign strb_lo = !ndstb_o || !nastb_o;

  assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ndstb_o && !nastb_o));

  assert_wr_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strb_lo) && !nwrite_o) |-> ($past(bus_oe_o) && !$past(nwrite_o)));

  assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_lo && $past(strb_lo) && !nwrite_o) |-> $stable(bus_o));

  assert_holdoff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(strb_lo) && !legacy_i && !$past(legacy_i)) |-> !$past(nwait_s));

  assert_end_on_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_lo) |-> ($past(nwait_s) || tmo_o));

  assert_done_after_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_valid_q && !tmo_o) |-> !$past(nwait_s));

  assert_rd_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_lo && nwrite_o) |-> !bus_oe_o);

  assert_idle_levels_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ndstb_o && nastb_o && nwrite_o && !bus_oe_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind epp_host_ctrl epp_host_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .legacy_i(legacy_i), .done_o(done_o),
  .tmo_o(tmo_o), .nwrite_o(nwrite_o), .ndstb_o(ndstb_o), .nastb_o(nastb_o),
  .bus_o(bus_o), .bus_oe_o(bus_oe_o), .nwait_s(nwait_s), .op_valid_q(op_valid_q)
);

// File: tb/epp_host_ctrl_bench.sv
`timescale 1ns/1ps
module epp_host_ctrl_bench;
  localparam int DW = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          legacy_i = 1'b0;
  logic [TW-1:0] tmo_lim_i = '0;
  logic          req_i = 1'b0;
  logic [2:0]    req_off_i = '0;
  logic          req_we_i = 1'b0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          done_o, tmo_o, nwrite_o, ndstb_o, nastb_o, bus_oe_o;
  logic [DW-1:0] rdata_o, bus_o;
  logic [DW-1:0] bus_i;
  logic          nwait_i;

  always #10 clk = ~clk;

  epp_host_ctrl u_epp_host_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .legacy_i(legacy_i), .tmo_lim_i(tmo_lim_i),
    .req_i(req_i), .req_off_i(req_off_i), .req_we_i(req_we_i),
    .req_wdata_i(req_wdata_i), .done_o(done_o), .rdata_o(rdata_o),
    .tmo_o(tmo_o), .nwrite_o(nwrite_o), .ndstb_o(ndstb_o), .nastb_o(nastb_o),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i), .nwait_i(nwait_i)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // peripheral model controls
  int            p_dly = 0;
  bit            p_hang = 0;
  bit            p_pre_high = 0;
  logic [DW-1:0] p_rdata = '0;
  // peripheral observations
  int            strb_cnt = 0;
  logic          cap_dstb, cap_astb, cap_nwrite, cap_oe, pre_oe, cap_pre_oe;
  logic [DW-1:0] cap_data, pre_data, cap_pre_data, cap_end_data;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  initial begin
    nwait_i = 1'b0;
    bus_i = '0;
    forever begin
      @(negedge clk);
      if (ndstb_o && nastb_o) begin
        nwait_i = p_pre_high;
        pre_oe = bus_oe_o;
        pre_data = bus_o;
      end else begin
        strb_cnt++;
        cap_dstb = !ndstb_o;
        cap_astb = !nastb_o;
        cap_nwrite = nwrite_o;
        cap_oe = bus_oe_o;
        cap_data = bus_o;
        cap_pre_oe = pre_oe;
        cap_pre_data = pre_data;
        repeat (p_dly) @(negedge clk);
        if (!p_hang) begin
          bus_i = p_rdata;
          nwait_i = 1'b1;
        end
        while (!(ndstb_o && nastb_o)) begin
          cap_end_data = bus_o;
          @(negedge clk);
        end
        if (!p_hang) begin
          repeat (p_dly) @(negedge clk);
          nwait_i = 1'b0;
        end
      end
    end
  end

  task automatic issue(input logic [2:0] off, input bit we, input logic [DW-1:0] wd);
    @(negedge clk);
    req_i = 1'b1; req_off_i = off; req_we_i = we; req_wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done_o == 1'b1, {tag, " completion"}, done_o, 1);
  endtask

  task automatic idle_after(input string tag);
    @(negedge clk);
    chk(done_o == 1'b0, {"R11 done one clock ", tag}, done_o, 0);
    chk({nwrite_o, ndstb_o, nastb_o, bus_oe_o} == 4'b1110,
        {"R9 idle levels ", tag}, {nwrite_o, ndstb_o, nastb_o, bus_oe_o}, 4'b1110);
  endtask

  task automatic txn(input logic [2:0] off, input bit we, input logic [DW-1:0] v, input int dly);
    int c0;
    p_dly = dly;
    p_rdata = ~v;
    c0 = strb_cnt;
    issue(off, we, v);
    wait_done("R5");
    chk(tmo_o == 1'b0, "R5 no timeout", tmo_o, 0);
    chk(strb_cnt == c0 + 1, "R1 one strobe per request", strb_cnt - c0, 1);
    if (off == 3'd4) chk(cap_dstb && !cap_astb, "R1 data strobe", {cap_dstb, cap_astb}, 2'b10);
    else             chk(!cap_dstb && cap_astb, "R1 address strobe", {cap_dstb, cap_astb}, 2'b01);
    if (we) begin
      chk(cap_nwrite == 1'b0 && cap_oe == 1'b1, "R2 write direction",
          {cap_nwrite, cap_oe}, 2'b01);
      chk(cap_pre_oe == 1'b1 && cap_pre_data == v, "R2 data before strobe", cap_pre_data, v);
      chk(cap_data == v && cap_end_data == v, "R2 data held", cap_end_data, v);
    end else begin
      chk(cap_nwrite == 1'b1 && cap_oe == 1'b0, "R7 read direction",
          {cap_nwrite, cap_oe}, 2'b10);
      chk(rdata_o == ~v, "R7 read data", rdata_o, ~v);
    end
    idle_after("txn");
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk({nwrite_o, ndstb_o, nastb_o, bus_oe_o, done_o} == 5'b11100, "R9 in reset",
        {nwrite_o, ndstb_o, nastb_o, bus_oe_o, done_o}, 5'b11100);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({nwrite_o, ndstb_o, nastb_o, bus_oe_o, done_o} == 5'b11100, "R9 after reset",
        {nwrite_o, ndstb_o, nastb_o, bus_oe_o, done_o}, 5'b11100);

    // sweep: both cycle kinds, both directions, values and response delays
    for (int off = 3; off <= 4; off++)
      for (int we = 0; we <= 1; we++)
        for (int v = 0; v < 256; v += 15)
          txn(3'(off), we[0], 8'(v), v % 4);

    // R10: other offsets complete without bus activity
    for (int off = 0; off < 8; off++) begin
      if (off == 3 || off == 4) continue;
      c0 = strb_cnt;
      issue(3'(off), 1'b1, 8'h3c);
      wait_done("R10");
      chk(strb_cnt == c0 && tmo_o == 1'b0, "R10 no strobe for other offset", strb_cnt - c0, 0);
      idle_after("R10");
    end

    // R3: compliant hold-off while wait is high, limit disabled
    tmo_lim_i = '0;
    p_pre_high = 1'b1; p_dly = 1; p_rdata = 8'h96;
    repeat (4) @(negedge clk);
    c0 = strb_cnt;
    issue(3'd4, 1'b0, 8'h00);
    repeat (20) @(negedge clk);
    chk(strb_cnt == c0, "R3 no strobe while wait high", strb_cnt - c0, 0);
    chk(done_o == 1'b0, "R3 no completion while wait high", done_o, 0);
    p_pre_high = 1'b0;
    wait_done("R3");
    chk(strb_cnt == c0 + 1 && tmo_o == 1'b0, "R3 cycle after wait low", strb_cnt - c0, 1);
    chk(rdata_o == 8'h96, "R7 read after hold-off", rdata_o, 8'h96);
    idle_after("R3");

    // R6: legacy mode strobes even though wait is high
    legacy_i = 1'b1;
    p_pre_high = 1'b1; p_dly = 0;
    repeat (4) @(negedge clk);
    c0 = strb_cnt;
    issue(3'd3, 1'b1, 8'hc5);
    wait_done("R6");
    chk(strb_cnt == c0 + 1, "R6 legacy strobe with wait high", strb_cnt - c0, 1);
    chk(cap_astb && cap_data == 8'hc5, "R6 legacy write address", cap_data, 8'hc5);
    chk(tmo_o == 1'b0, "R6 no timeout", tmo_o, 0);
    idle_after("R6");
    p_pre_high = 1'b0;
    legacy_i = 1'b0;
    repeat (4) @(negedge clk);

    // R8: peripheral never answers, strobe times out
    tmo_lim_i = 8'd6;
    p_hang = 1'b1;
    c0 = strb_cnt;
    issue(3'd4, 1'b0, 8'h00);
    wait_done("R8");
    chk(tmo_o == 1'b1, "R8 timeout during strobe", tmo_o, 1);
    chk(strb_cnt == c0 + 1, "R8 strobe was issued", strb_cnt - c0, 1);
    chk(ndstb_o && nastb_o, "R8 strobes released", {ndstb_o, nastb_o}, 2'b11);
    idle_after("R8");
    p_hang = 1'b0;
    repeat (4) @(negedge clk);

    // R8: timeout before strobe while wait held high
    tmo_lim_i = 8'd4;
    p_pre_high = 1'b1;
    repeat (4) @(negedge clk);
    c0 = strb_cnt;
    issue(3'd3, 1'b1, 8'h11);
    wait_done("R8");
    chk(tmo_o == 1'b1, "R8 timeout before strobe", tmo_o, 1);
    chk(strb_cnt == c0, "R8 no strobe on early timeout", strb_cnt - c0, 0);
    p_pre_high = 1'b0;
    repeat (4) @(negedge clk);

    // R11: next good request clears the timeout flag
    txn(3'd4, 1'b1, 8'h7e, 2);
    chk(tmo_o == 1'b0, "R11 timeout flag cleared", tmo_o, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule